// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the configuration state of a four-bank SDRAM controller and turns that state into an address decode. A narrow register bus reaches it through two bus numbers. The bus number `0x010` is an index port, and a write there picks an internal register. The bus number `0x011` is a window onto the register the index currently selects, and reads and writes through it act on that register. The registers cover error capture, global configuration and its status, refresh and idle timers, controller timing, ECC setup and ECC error status, and one configuration word per bank.

Each bank word gives an enable bit, a base address aligned to 8 MiB and a size code for a power-of-two size. When the global enable is set, the block compares an incoming physical address against every active bank. It reports whether any bank claims the address and which bank does so. A write to the ECC error status that moves it between zero and non-zero raises or drops an interrupt line. Command sequencing, the memory datapath and ECC generation sit elsewhere.

Every bus access completes in the cycle it is presented. A read returns its data one cycle later, with `rsp_valid` high. There is no back-pressure, because the block accepts every request.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write to bus number 0x010 stores the full 32-bit value as the index, and a read of 0x010 returns it. Requests on any other bus number except 0x011 change no state.
- R2: A read of 0x010 or 0x011 presented in one cycle gives `rsp_valid` high with the data in the next cycle. The data reflects the state before any write in that same cycle.
- R3: Through 0x011 the index selects registers as follows: 0x00 error status A, 0x08 error status B, 0x10 error address, 0x20 config, 0x24 status, 0x30 refresh timer, 0x34 idle timer, 0x40 + 4·n bank n config, 0x80 timing, 0x94 ECC config, 0x98 ECC error status. The timing index and every unlisted index read as 0xFFFFFFFF.
- R4: Error status A and B are write-one-to-clear. The error address stores the written value. Writes to the status register are ignored.
- R5: A config write stores the value ANDed with 0xFFE00000. When bit 31 (global enable) goes 0→1, status bit 31 clears. When it goes 1→0, status bit 31 sets.
- R6: When config bit 30 goes 0→1, status bit 30 sets. When it goes 1→0, status bit 30 clears.
- R7: The refresh timer stores the written value ANDed with 0x3FF80000. ECC config stores it ANDed with 0x00F00000. The idle timer stores bits 31:27 of the written value and always holds bits 26:22 at one.
- R8: A bank config write stores the value ANDed with 0xFFDEE001. In that word, bit 0 is the bank enable, bits 31:23 are the base address bits 31:23, and bits 19:17 are the size code. The size is 4 MiB << code, and code 7 is invalid.
- R9: A bank is active only when the global enable, its enable bit and a valid size code are all set. An active bank claims `phys_addr` in base … base+size−1, including a range that ends at 0xFFFFFFFF. `hit` is high when any bank claims the address.
- R10: When several banks claim an address, `hit_bank` gives the lowest-numbered one.
- R11: An ECC error status write stores the value ANDed with 0xFFF0F000. `ecc_irq` rises when the stored value goes from zero to non-zero and falls when it goes from non-zero to zero. It becomes visible the cycle after the write.
- R12: After reset, the register values are: index 0, config 0x00800000, status 0, refresh timer 0x05F00000, idle timer 0x07C00000, error, error address, ECC and bank registers 0, and `ecc_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_num | input | 10 | Bus register number |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| phys_addr | input | 32 | Physical address to decode |
| bank_active | output | 4 | Per-bank active flag |
| hit | output | 1 | Some active bank claims `phys_addr` |
| hit_bank | output | 2 | Index of the claiming bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The bench drives the config register through both enable edges and both self-refresh edges. A design with a swapped polarity would leave the wrong status bit set. A bank is placed at the top of the 4 GiB space, where a 32-bit limit sum would wrap, so a design without a carry bit would miss address 0xFFFFFFFF. Two banks are made to overlap so that a reversed priority encoder would report bank 2. A bank with size code 7 and a bank with its enable cleared are probed, because both must stay silent. ECC status writes cover a value that masks to zero, a non-zero-to-non-zero write and a clear; a design that toggles the interrupt on every write would fail on the second of these.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  // indirect register indices behind the data port
  localparam logic [31:0] IX_ERR_A   = 32'h00;
  localparam logic [31:0] IX_ERR_B   = 32'h08;
  localparam logic [31:0] IX_EADDR   = 32'h10;
  localparam logic [31:0] IX_CFG     = 32'h20;
  localparam logic [31:0] IX_STAT    = 32'h24;
  localparam logic [31:0] IX_RFSH    = 32'h30;
  localparam logic [31:0] IX_IDLE    = 32'h34;
  localparam logic [31:0] IX_BANK0   = 32'h40;
  localparam logic [31:0] IX_TIMING  = 32'h80;
  localparam logic [31:0] IX_ECCCFG  = 32'h94;
  localparam logic [31:0] IX_ECCERR  = 32'h98;

  // write masks and forced bits
  localparam logic [31:0] M_CFG      = 32'hFFE0_0000;
  localparam logic [31:0] M_RFSH     = 32'h3FF8_0000;
  localparam logic [31:0] M_IDLE     = 32'hF800_0000;
  localparam logic [31:0] F_IDLE     = 32'h07C0_0000;
  localparam logic [31:0] M_BANK     = 32'hFFDE_E001;
  localparam logic [31:0] M_ECCCFG   = 32'h00F0_0000;
  localparam logic [31:0] M_ECCERR   = 32'hFFF0_F000;

  // reset values
  localparam logic [31:0] R_CFG      = 32'h0080_0000;
  localparam logic [31:0] R_RFSH     = 32'h05F0_0000;
  localparam logic [31:0] ALL_ONES   = 32'hFFFF_FFFF;

  // config / status bit positions shared by both registers
  localparam int B_GEN = 31;
  localparam int B_SLF = 30;

  // 4 MiB, widened with a carry bit for limit arithmetic
  localparam logic [32:0] UNIT_SIZE  = 33'h0_0040_0000;
endpackage

// File: rtl/sdcfg_bank_decode.sv
module sdcfg_bank_decode
  import sdcfg_pkg::*;
(
  input  logic        glb_en,
  input  logic        bank_en,
  input  logic [8:0]  base_hi,
  input  logic [2:0]  size_code,
  input  logic [31:0] phys_addr,
  output logic        active,
  output logic        claim
);
  logic [32:0] lo_q;
  logic [32:0] hi_q;
  logic [32:0] addr_x;

  always_comb begin
    lo_q   = {1'b0, base_hi, 23'b0};
    hi_q   = lo_q + (UNIT_SIZE << size_code);
    addr_x = {1'b0, phys_addr};
    active = glb_en && bank_en && (size_code != 3'd7);
    claim  = active && (addr_x >= lo_q) && (addr_x < hi_q);
  end
endmodule

// File: rtl/sdcfg_prio.sv
module sdcfg_prio #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdcfg_pkg::*;
#(
  parameter int                NBANK     = 4,
  parameter int                NUM_W     = 10,
  parameter logic [NUM_W-1:0]  PORT_IDX  = 10'h010,
  parameter logic [NUM_W-1:0]  PORT_WIN  = 10'h011,
  localparam int               BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [31:0]       phys_addr,
  output logic [NBANK-1:0]  bank_active,
  output logic              hit,
  output logic [BANK_W-1:0] hit_bank,
  output logic              ecc_irq
);
  logic [31:0] idx_q, err_a_q, err_b_q, eaddr_q, cfg_q, stat_q;
  logic [31:0] rfsh_q, idle_q, ecccfg_q, eccerr_q;
  logic [31:0] bank_q [NBANK];
  logic        irq_q;

  logic        wr_idx, wr_win, rd_any, rd_idx;
  logic [NBANK-1:0] bank_sel, bank_claim;
  logic [31:0] win_val, cfg_new, ecc_new;

  assign wr_idx  = req_valid && req_write && (req_num == PORT_IDX);
  assign wr_win  = req_valid && req_write && (req_num == PORT_WIN);
  assign rd_idx  = req_valid && !req_write && (req_num == PORT_IDX);
  assign rd_any  = req_valid && !req_write && ((req_num == PORT_IDX) || (req_num == PORT_WIN));
  assign cfg_new = req_wdata & M_CFG;
  assign ecc_new = req_wdata & M_ECCERR;

  for (genvar i = 0; i < NBANK; i++) begin : g_sel
    assign bank_sel[i] = (idx_q == IX_BANK0 + 32'(4 * i));
  end

  // window read mux
  always_comb begin
    win_val = ALL_ONES;
    case (idx_q)
      IX_ERR_A:  win_val = err_a_q;
      IX_ERR_B:  win_val = err_b_q;
      IX_EADDR:  win_val = eaddr_q;
      IX_CFG:    win_val = cfg_q;
      IX_STAT:   win_val = stat_q;
      IX_RFSH:   win_val = rfsh_q;
      IX_IDLE:   win_val = idle_q;
      IX_ECCCFG: win_val = ecccfg_q;
      IX_ECCERR: win_val = eccerr_q;
      default:   win_val = ALL_ONES;
    endcase
    for (int i = 0; i < NBANK; i++) begin
      if (bank_sel[i]) win_val = bank_q[i];
    end
  end

  // register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      err_a_q   <= '0;
      err_b_q   <= '0;
      eaddr_q   <= '0;
      cfg_q     <= R_CFG;
      stat_q    <= '0;
      rfsh_q    <= R_RFSH;
      idle_q    <= F_IDLE;
      ecccfg_q  <= '0;
      eccerr_q  <= '0;
      irq_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
    end else begin
      rsp_valid <= rd_any;
      if (rd_any) rsp_rdata <= rd_idx ? idx_q : win_val;
      if (wr_idx) idx_q <= req_wdata;
      if (wr_win) begin
        case (idx_q)
          IX_ERR_A:  err_a_q  <= err_a_q & ~req_wdata;
          IX_ERR_B:  err_b_q  <= err_b_q & ~req_wdata;
          IX_EADDR:  eaddr_q  <= req_wdata;
          IX_CFG: begin
            if (!cfg_q[B_GEN] && cfg_new[B_GEN])      stat_q[B_GEN] <= 1'b0;
            else if (cfg_q[B_GEN] && !cfg_new[B_GEN]) stat_q[B_GEN] <= 1'b1;
            if (!cfg_q[B_SLF] && cfg_new[B_SLF])      stat_q[B_SLF] <= 1'b1;
            else if (cfg_q[B_SLF] && !cfg_new[B_SLF]) stat_q[B_SLF] <= 1'b0;
            cfg_q <= cfg_new;
          end
          IX_RFSH:   rfsh_q   <= req_wdata & M_RFSH;
          IX_IDLE:   idle_q   <= (req_wdata & M_IDLE) | F_IDLE;
          IX_ECCCFG: ecccfg_q <= req_wdata & M_ECCCFG;
          IX_ECCERR: begin
            if (eccerr_q == '0 && ecc_new != '0)      irq_q <= 1'b1;
            else if (eccerr_q != '0 && ecc_new == '0) irq_q <= 1'b0;
            eccerr_q <= ecc_new;
          end
          default: ;
        endcase
        for (int i = 0; i < NBANK; i++) begin
          if (bank_sel[i]) bank_q[i] <= req_wdata & M_BANK;
        end
      end
    end
  end

  assign ecc_irq = irq_q;

  // per-bank address decode
  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    sdcfg_bank_decode u_dec (
      .glb_en    (cfg_q[B_GEN]),
      .bank_en   (bank_q[i][0]),
      .base_hi   (bank_q[i][31:23]),
      .size_code (bank_q[i][19:17]),
      .phys_addr (phys_addr),
      .active    (bank_active[i]),
      .claim     (bank_claim[i])
    );
  end

  sdcfg_prio #(.N(NBANK)) u_prio (
    .req (bank_claim),
    .any (hit),
    .idx (hit_bank)
  );

  // checks kept next to the logic they watch
  logic [NBANK-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (BANK_W'(i) < hit_bank) below_mask[i] = 1'b1;
    end
  end

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rsp_valid);
  assert_status_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && idx_q == IX_STAT) |=> $stable(stat_q));
  assert_cfg_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[20:0] == '0);
  assert_idle_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q[26:22] == 5'h1F);
  assert_no_hit_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[B_GEN] |-> (!hit && bank_active == '0));
  assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (bank_claim[hit_bank] && (bank_claim & below_mask) == '0));
  assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_irq == (eccerr_q != '0));
endmodule

// File: tb/test_sdram_cfg_regs.sv
`timescale 1ns/1ps
module test_sdram_cfg_regs;
  localparam logic [9:0] P_IDX = 10'h010;
  localparam logic [9:0] P_WIN = 10'h011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [9:0]  req_num = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] phys_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  bank_active;
  logic        hit;
  logic [1:0]  hit_bank;
  logic        ecc_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  sdram_cfg_regs i_sdram_cfg_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .phys_addr(phys_addr), .bank_active(bank_active),
    .hit(hit), .hit_bank(hit_bank), .ecc_irq(ecc_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each read response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected response", 32'h1, 32'h0);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus(input logic we, input logic [9:0] num, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_num = num; req_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  task automatic rd(input logic [9:0] num, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_num = num; req_wdata = '0;
  endtask

  task automatic wreg(input logic [31:0] ix, input logic [31:0] d);
    bus(1'b1, P_IDX, ix);
    bus(1'b1, P_WIN, d);
  endtask

  task automatic rreg(input logic [31:0] ix, input logic [31:0] exp, input string tag);
    bus(1'b1, P_IDX, ix);
    rd(P_WIN, exp, tag);
  endtask

  task automatic probe(input logic [31:0] a, input logic eh, input logic [1:0] eb, input string tag);
    @(negedge clk);
    phys_addr = a;
    #1;
    chk({tag, " hit"}, {31'b0, hit}, {31'b0, eh});
    if (eh) chk({tag, " bank"}, {30'b0, hit_bank}, {30'b0, eb});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset values
    chk("R12 irq reset", {31'b0, ecc_irq}, 32'h0);
    chk("R12 hit reset", {31'b0, hit}, 32'h0);
    rd(P_IDX, 32'h0, "R12 index reset");
    rreg(32'h20, 32'h0080_0000, "R12 cfg reset");
    rreg(32'h24, 32'h0, "R12 status reset");
    rreg(32'h30, 32'h05F0_0000, "R12 refresh reset");
    rreg(32'h34, 32'h07C0_0000, "R12 idle reset");
    rreg(32'h98, 32'h0, "R12 ecc err reset");
    rreg(32'h4C, 32'h0, "R12 bank3 reset");
    // R3 all-ones reads
    rreg(32'h80, 32'hFFFF_FFFF, "R3 timing reads ones");
    rreg(32'h04, 32'hFFFF_FFFF, "R3 unknown index");
    // R1 index port and foreign numbers
    bus(1'b1, P_IDX, 32'hDEAD_0010);
    bus(1'b1, 10'h012, 32'h0000_0055);
    rd(P_IDX, 32'hDEAD_0010, "R1 index readback, foreign write ignored");
    // R4
    wreg(32'h10, 32'h1234_5678);
    rreg(32'h10, 32'h1234_5678, "R4 error address");
    wreg(32'h00, 32'hFFFF_FFFF);
    rreg(32'h00, 32'h0, "R4 error status A w1c");
    wreg(32'h24, 32'hFFFF_FFFF);
    rreg(32'h24, 32'h0, "R4 status ignores write");
    // R5/R6 config transitions
    wreg(32'h20, 32'hFFFF_FFFF);
    rreg(32'h20, 32'hFFE0_0000, "R5 cfg masked");
    rreg(32'h24, 32'h4000_0000, "R6 self-refresh rise sets status");
    wreg(32'h20, 32'h0);
    rreg(32'h24, 32'h8000_0000, "R5 disable sets status");
    // R7
    wreg(32'h30, 32'hFFFF_FFFF);
    rreg(32'h30, 32'h3FF8_0000, "R7 refresh mask");
    wreg(32'h34, 32'h0);
    rreg(32'h34, 32'h07C0_0000, "R7 idle forced");
    wreg(32'h34, 32'hFFFF_FFFF);
    rreg(32'h34, 32'hFFC0_0000, "R7 idle high bits");
    wreg(32'h94, 32'hFFFF_FFFF);
    rreg(32'h94, 32'h00F0_0000, "R7 ecc cfg mask");
    // R8 bank programming
    wreg(32'h40, 32'h0082_0001);          // base 8 MiB, 8 MiB
    wreg(32'h44, 32'hFFFF_FFFF);
    rreg(32'h44, 32'hFFDE_E001, "R8 bank mask");
    wreg(32'h48, 32'h0004_0001);          // base 0, 16 MiB
    wreg(32'h4C, 32'hF00C_0001);          // base 0xF0000000, 256 MiB
    idle(2);
    probe(32'h0090_0000, 1'b0, 2'd0, "R9 global off");
    wreg(32'h20, 32'h8000_0000);
    idle(2);
    rreg(32'h24, 32'h0, "R5 enable clears status");
    idle(2);
    chk("R9 active set", {28'b0, bank_active}, 32'h0000_000D);
    probe(32'h0090_0000, 1'b1, 2'd0, "R10 overlap lowest");
    probe(32'h0010_0000, 1'b1, 2'd2, "R9 bank2 only");
    probe(32'h00FF_FFFF, 1'b1, 2'd0, "R9 bank0 top edge");
    probe(32'h0100_0000, 1'b0, 2'd0, "R9 past end");
    probe(32'hFF90_0000, 1'b1, 2'd3, "R9 code7 bank1 silent");
    probe(32'hFFFF_FFFF, 1'b1, 2'd3, "R9 top of space");
    wreg(32'h4C, 32'hF00C_0000);
    idle(2);
    probe(32'hFFFF_FFFF, 1'b0, 2'd0, "R9 bank enable off");
    // R11 ECC interrupt
    wreg(32'h98, 32'h0000_0123);
    idle(1);
    chk("R11 masked to zero no irq", {31'b0, ecc_irq}, 32'h0);
    wreg(32'h98, 32'hFFFF_FFFF);
    idle(1);
    chk("R11 irq rises", {31'b0, ecc_irq}, 32'h1);
    wreg(32'h98, 32'h0000_1000);
    idle(1);
    chk("R11 irq holds", {31'b0, ecc_irq}, 32'h1);
    rreg(32'h98, 32'h0000_1000, "R11 ecc err value");
    wreg(32'h98, 32'h0);
    idle(1);
    chk("R11 irq falls", {31'b0, ecc_irq}, 32'h0);
    idle(4);
    chk("R2 scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule